// File: doc/BRIEF.md
# SD Error-Check Packet Monitor and Inserter

This block sits in a 10-bit standard-definition parallel video path. It watches the stream for error-check ancillary packets. From each packet it takes three five-bit flag words: full field, active picture and ancillary. It keeps the latest value of each word in a readable register and derives one error bit for each group, plus an overall error bit. Every word reaches the output one clock later. When insertion is forced, the checkword and flag words in the packet payload are replaced with locally generated values, whatever the packet carried.

Two CRC-16 accumulators run alongside the stream. One covers the active-picture region and one covers the full-field region. Each region's window strobe comes from outside, and so does a field-start strobe. At every field start the finished CRC of the previous field is latched for insertion, and the accumulator restarts. A small register port carries the enable and force controls and returns status. Payload positions use this layout, in this order: full-field flags, active-picture flags, ancillary flags, active-picture CRC high byte and low byte, full-field CRC high byte and low byte. Each payload word holds a byte in bits [7:0], even parity of that byte in bit 8, and the inverse of bit 8 in bit 9.

The packet parser is a finite-state machine with five states:
- IDLE moves to ZERO on word 0x000.
- ZERO moves to ONE_A on 0x3FF.
- ONE_A moves to ONE_B on 0x3FF.
- ONE_B moves to PAYLOAD on data identifier 0x1F4.
- PAYLOAD returns to IDLE after its seventh payload word.

Any other word returns ZERO, ONE_A or ONE_B to IDLE, except that 0x000 re-enters ZERO. Words with `vid_valid` low never move the parser.

Top module: `edh_guard`

## Requirements
- R1: After reset, every readable register reads 0 and `out_valid` is 0. Both latched CRC values are 0, so a forced packet sent before any field start carries 0x200 in all seven payload words.
- R2: `out_valid` equals `vid_valid` one cycle later. When the block neither forces nor is disabled-bypassed in a payload position, `out_data` equals the `vid_data` of the previous cycle.
- R3: With the enable bit (control bit 0) low, the output is the input delayed one cycle, even if the force bit is set, and the stored flags do not change.
- R4: A packet is recognised only when 0x000, 0x3FF, 0x3FF and 0x1F4 arrive on consecutive valid words. A broken prefix captures nothing.
- R5: While enabled, payload words 0, 1 and 2 load their bits [4:0] into the full-field (address 2), active-picture (address 3) and ancillary (address 4) flag registers. Bit 0 of a flag word is EDH, bit 1 is EDA, bit 2 is IDH, bit 3 is IDA and bit 4 is UES.
- R6: In the status register (address 1), bit 0 (full field), bit 1 (active picture) and bit 2 (ancillary) each equal bit 0 OR bit 1 of their flag register.
- R7: Status bit 3 is set when any of the fifteen stored flag bits is set.
- R8: With enable and force both set (control bits 0 and 1), payload words 0 to 2 leave as 0x200. Payload words 3 to 6 leave as the encoded latched CRC bytes. The received flags are still captured in the same cycle.
- R9: Each CRC uses polynomial 0x1021 with a zero start. It shifts MSB-first and feeds the ten word bits in order from bit 0 to bit 9. It covers valid words whose window strobe is high. On a field-start cycle the running value is latched and the accumulator restarts, and that cycle's word is the first one included.
- R10: Words with `vid_valid` low inside a packet are skipped by the parser and the CRCs.
- R11: Address 0 reads back the written enable and force bits. Writes to any other address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vid_valid | input | 1 | Input word present |
| vid_data | input | 10 | Input video word |
| field_start | input | 1 | First cycle of a field |
| ap_window | input | 1 | Word lies in the active-picture region |
| ff_window | input | 1 | Word lies in the full-field region |
| out_valid | output | 1 | Output word present |
| out_data | output | 10 | Output video word |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |

## Verification
Capture and insertion fall in the same cycle when a forced packet arrives carrying error flags. The bench sends such a packet. It compares each output word against 0x200 or the encoded CRC bytes, and afterwards reads the flag and status registers to confirm they hold the received values. A second collision lines up a field-start pulse with a word inside both windows. The next forced packet must carry a CRC that starts from that word, which the bench works out arithmetically.

// File: rtl/edh_guard_pkg.sv
package edh_guard_pkg;

    localparam int WORD_W  = 10;
    localparam int BYTE_W  = 8;
    localparam int FLAG_W  = 5;
    localparam int PAY_LEN = 7;
    localparam int IDX_W   = $clog2(PAY_LEN);

    localparam logic [WORD_W-1:0] PFX_ZERO = 10'h000;
    localparam logic [WORD_W-1:0] PFX_ONES = 10'h3FF;
    localparam logic [WORD_W-1:0] PKT_DID  = 10'h1F4;

    // payload positions
    localparam int POS_FF  = 0;
    localparam int POS_AP  = 1;
    localparam int POS_ANC = 2;
    localparam int POS_APH = 3;
    localparam int POS_APL = 4;
    localparam int POS_FFH = 5;
    localparam int POS_FFL = 6;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_ZERO,
        PS_ONE_A,
        PS_ONE_B,
        PS_PAYLOAD
    } pstate_t;

    function automatic logic [WORD_W-1:0] enc_byte(input logic [BYTE_W-1:0] b);
        logic p;
        p = ^b;
        return {~p, p, b};
    endfunction

endpackage

// File: rtl/edh_crc_acc.sv
module edh_crc_acc #(
    parameter int DATA_W = 10,
    parameter int CRC_W  = 16,
    parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [DATA_W-1:0] data,
    input  logic              window,
    input  logic              field_start,
    output logic [CRC_W-1:0]  held
);

    logic [CRC_W-1:0] acc_q;
    logic [CRC_W-1:0] held_q;
    logic [CRC_W-1:0] base;
    logic [CRC_W-1:0] acc_d;

    function automatic logic [CRC_W-1:0] crc_word(input logic [CRC_W-1:0] c,
                                                  input logic [DATA_W-1:0] d);
        logic [CRC_W-1:0] r;
        logic fb;
        r = c;
        for (int i = 0; i < DATA_W; i++) begin
            fb = r[CRC_W-1] ^ d[i];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ POLY;
        end
        return r;
    endfunction

    always_comb begin
        base  = field_start ? '0 : acc_q;
        acc_d = (valid && window) ? crc_word(base, data) : base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            held_q <= '0;
        end else begin
            acc_q <= acc_d;
            if (field_start) held_q <= acc_q;
        end
    end

    assign held = held_q;

    // R9: latched value only moves at a field start
    a_r9_held_only_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        !field_start |=> $stable(held_q));

    // R10: skipped or out-of-window words leave the accumulator alone
    a_r10_acc_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!field_start && !(valid && window)) |=> $stable(acc_q));

endmodule

// File: rtl/edh_pkt_parser.sv
module edh_pkt_parser
    import edh_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [WORD_W-1:0] data,
    output logic              pay_hit,
    output logic [IDX_W-1:0]  pay_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAY_LEN - 1);

    pstate_t          state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        if (valid) begin
            unique case (state_q)
                PS_IDLE:  state_d = (data == PFX_ZERO) ? PS_ZERO : PS_IDLE;
                PS_ZERO:
                    if (data == PFX_ONES)      state_d = PS_ONE_A;
                    else if (data == PFX_ZERO) state_d = PS_ZERO;
                    else                       state_d = PS_IDLE;
                PS_ONE_A:
                    if (data == PFX_ONES)      state_d = PS_ONE_B;
                    else if (data == PFX_ZERO) state_d = PS_ZERO;
                    else                       state_d = PS_IDLE;
                PS_ONE_B:
                    if (data == PKT_DID) begin
                        state_d = PS_PAYLOAD;
                        idx_d   = '0;
                    end else if (data == PFX_ZERO) state_d = PS_ZERO;
                    else                           state_d = PS_IDLE;
                PS_PAYLOAD:
                    if (idx_q == LAST_IDX) state_d = PS_IDLE;
                    else                   idx_d   = idx_q + 1'b1;
                default: state_d = PS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        pay_hit = valid && (state_q == PS_PAYLOAD);
        pay_idx = idx_q;
    end

    // R4: payload index never runs past the last payload word
    a_r4_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_PAYLOAD) |-> (idx_q <= LAST_IDX));

    // R10: parser holds still on empty cycles
    a_r10_parser_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(state_q));

endmodule

// File: rtl/edh_guard.sv
module edh_guard
    import edh_guard_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int REG_W  = 8,
    parameter int CRC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vid_valid,
    input  logic [9:0]        vid_data,
    input  logic              field_start,
    input  logic              ap_window,
    input  logic              ff_window,
    output logic              out_valid,
    output logic [9:0]        out_data,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata
);

    localparam int N_REGION = 2;   // 0: active picture, 1: full field

    logic              en_q, force_q;
    logic [FLAG_W-1:0] ff_q, ap_q, anc_q;
    logic              pay_hit;
    logic [IDX_W-1:0]  pay_idx;
    logic [N_REGION-1:0] win;
    logic [CRC_W-1:0]  held [N_REGION];
    logic [WORD_W-1:0] gen_word;
    logic [WORD_W-1:0] out_q;
    logic              out_v_q;
    logic              ff_err, ap_err, anc_err, sd_err;

    assign win = {ff_window, ap_window};

    edh_pkt_parser u_parser (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (vid_valid),
        .data    (vid_data),
        .pay_hit (pay_hit),
        .pay_idx (pay_idx)
    );

    for (genvar g = 0; g < N_REGION; g++) begin : g_crc
        edh_crc_acc #(.DATA_W(WORD_W), .CRC_W(CRC_W)) u_crc (
            .clk         (clk),
            .rst_n       (rst_n),
            .valid       (vid_valid),
            .data        (vid_data),
            .window      (win[g]),
            .field_start (field_start),
            .held        (held[g])
        );
    end

    // locally generated payload word
    always_comb begin
        unique case (int'(pay_idx))
            POS_APH: gen_word = enc_byte(held[0][CRC_W-1:BYTE_W]);
            POS_APL: gen_word = enc_byte(held[0][BYTE_W-1:0]);
            POS_FFH: gen_word = enc_byte(held[1][CRC_W-1:BYTE_W]);
            POS_FFL: gen_word = enc_byte(held[1][BYTE_W-1:0]);
            default: gen_word = enc_byte('0);
        endcase
    end

    // control and flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            force_q <= 1'b0;
            ff_q    <= '0;
            ap_q    <= '0;
            anc_q   <= '0;
        end else begin
            if (reg_wr && reg_addr == '0) begin
                en_q    <= reg_wdata[0];
                force_q <= reg_wdata[1];
            end
            if (en_q && pay_hit) begin
                if (int'(pay_idx) == POS_FF)  ff_q  <= vid_data[FLAG_W-1:0];
                if (int'(pay_idx) == POS_AP)  ap_q  <= vid_data[FLAG_W-1:0];
                if (int'(pay_idx) == POS_ANC) anc_q <= vid_data[FLAG_W-1:0];
            end
        end
    end

    // output stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q   <= '0;
            out_v_q <= 1'b0;
        end else begin
            out_v_q <= vid_valid;
            out_q   <= (en_q && force_q && pay_hit) ? gen_word : vid_data;
        end
    end

    assign out_valid = out_v_q;
    assign out_data  = out_q;

    always_comb begin
        ff_err  = ff_q[0]  | ff_q[1];
        ap_err  = ap_q[0]  | ap_q[1];
        anc_err = anc_q[0] | anc_q[1];
        sd_err  = |{ff_q, ap_q, anc_q};
        unique case (reg_addr)
            3'd0:    reg_rdata = REG_W'({force_q, en_q});
            3'd1:    reg_rdata = REG_W'({sd_err, anc_err, ap_err, ff_err});
            3'd2:    reg_rdata = REG_W'(ff_q);
            3'd3:    reg_rdata = REG_W'(ap_q);
            3'd4:    reg_rdata = REG_W'(anc_q);
            default: reg_rdata = '0;
        endcase
    end

    // R2: output valid tracks input valid one cycle later
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(vid_valid)));

    // R3: disabled block is a pure one-cycle delay
    a_r3_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (out_data == $past(vid_data)));

    // R3: disabled block keeps its stored flags
    a_r3_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> ($stable(ff_q) && $stable(ap_q) && $stable(anc_q)));

    // R8: inserted words carry the parity/inverse-parity framing
    a_r8_insert_framed: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && force_q && pay_hit) |=> (out_data[9] == ~out_data[8]) &&
                                          (out_data[8] == ^out_data[7:0]));

    // R11: control write lands in the control register
    a_r11_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == '0) |=> (en_q == $past(reg_wdata[0])) &&
                                        (force_q == $past(reg_wdata[1])));

endmodule

// File: tb/edh_guard_tb.sv
module edh_guard_tb;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       vid_valid = 0;
    logic [9:0] vid_data = '0;
    logic       field_start = 0;
    logic       ap_window = 0;
    logic       ff_window = 0;
    logic       out_valid;
    logic [9:0] out_data;
    logic       reg_wr = 0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;

    int errors = 0;
    int checks = 0;

    // bench CRC model
    logic [15:0] m_acc_ap = 0, m_acc_ff = 0, m_held_ap = 0, m_held_ff = 0;

    always #5 clk = ~clk;

    edh_guard u_dut (
        .clk(clk), .rst_n(rst_n), .vid_valid(vid_valid), .vid_data(vid_data),
        .field_start(field_start), .ap_window(ap_window), .ff_window(ff_window),
        .out_valid(out_valid), .out_data(out_data), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [9:0] enc(input logic [7:0] b);
        return {~(^b), ^b, b};
    endfunction

    function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [9:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 10; i++) begin
            if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd_check(input logic [2:0] a, input int exp, input string req);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic sendw(input logic vv, input logic [9:0] d, input logic fs,
                         input logic apw, input logic ffw, input logic [9:0] exp,
                         input string req);
        logic [15:0] b_ap, b_ff;
        vid_valid = vv; vid_data = d; field_start = fs;
        ap_window = apw; ff_window = ffw;
        b_ap = fs ? 16'h0 : m_acc_ap;
        b_ff = fs ? 16'h0 : m_acc_ff;
        if (fs) begin
            m_held_ap = m_acc_ap;
            m_held_ff = m_acc_ff;
        end
        m_acc_ap = (vv && apw) ? crc_ref(b_ap, d) : b_ap;
        m_acc_ff = (vv && ffw) ? crc_ref(b_ff, d) : b_ff;
        @(negedge clk);
        check({req, " valid"}, out_valid, vv);
        if (vv) check(req, out_data, exp);
    endtask

    task automatic idle();
        sendw(0, 10'h000, 0, 0, 0, 10'h000, "R2 idle");
    endtask

    task automatic send_pkt(input logic [4:0] ff, input logic [4:0] ap,
                            input logic [4:0] anc, input logic gap,
                            input logic repl, input logic bad_pfx, input string req);
        logic [9:0] w [11];
        logic [9:0] g [7];
        logic [9:0] e;
        w[0] = 10'h000; w[1] = 10'h3FF; w[2] = bad_pfx ? 10'h155 : 10'h3FF;
        w[3] = 10'h1F4;
        w[4] = enc({3'b0, ff}); w[5] = enc({3'b0, ap}); w[6] = enc({3'b0, anc});
        w[7] = enc(8'hA5); w[8] = enc(8'h5A); w[9] = enc(8'h3C); w[10] = enc(8'hC3);
        g[0] = 10'h200; g[1] = 10'h200; g[2] = 10'h200;
        g[3] = enc(m_held_ap[15:8]); g[4] = enc(m_held_ap[7:0]);
        g[5] = enc(m_held_ff[15:8]); g[6] = enc(m_held_ff[7:0]);
        for (int i = 0; i < 11; i++) begin
            if (gap && i == 5) sendw(0, 10'h3FF, 0, 0, 0, 10'h000, "R10 gap");
            e = (repl && i >= 4) ? g[i-4] : w[i];
            sendw(1, w[i], 0, 0, 0, e, req);
        end
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [4:0] ff, ap, anc;
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 8; a++) rd_check(3'(a), 0, "R1 reset reg");
        check("R1 out_valid reset", out_valid, 0);
        rst_n = 1;
        @(negedge clk);

        // R3: disabled, even with force set: bypass, no capture
        wr(3'd0, 8'h02);
        send_pkt(5'h1F, 5'h03, 5'h11, 0, 0, 0, "R3 bypass");
        rd_check(3'd2, 0, "R3 ff not captured");
        rd_check(3'd1, 0, "R3 status unchanged");

        // R11: control read back; other writes ignored
        wr(3'd0, 8'h01);
        rd_check(3'd0, 1, "R11 ctrl readback");
        wr(3'd1, 8'hFF);
        wr(3'd2, 8'h1F);
        rd_check(3'd1, 0, "R11 status write ignored");
        rd_check(3'd2, 0, "R11 flag write ignored");

        // R5/R6/R7 sweep over all flag values, with gaps (R10)
        for (int v = 0; v < 32; v++) begin
            ff = 5'(v); ap = 5'((v * 7) % 32); anc = 5'((v * 13 + 3) % 32);
            send_pkt(ff, ap, anc, v[0], 0, 0, "R2 pass enabled");
            rd_check(3'd2, ff, "R5 ff flags");
            rd_check(3'd3, ap, "R5 ap flags");
            rd_check(3'd4, anc, "R5 anc flags");
            rd_check(3'd1, {|{ff, ap, anc}, anc[0] | anc[1], ap[0] | ap[1], ff[0] | ff[1]},
                     "R6 R7 status");
        end

        // R4: broken prefix captures nothing
        send_pkt(5'h00, 5'h00, 5'h00, 0, 0, 0, "R4 setup");
        send_pkt(5'h1F, 5'h1F, 5'h1F, 0, 0, 1, "R4 bad prefix pass");
        rd_check(3'd2, 0, "R4 bad prefix ff");
        rd_check(3'd1, 0, "R4 bad prefix status");

        // R1/R8: forced before any field start -> zero CRC; capture alongside
        wr(3'd0, 8'h03);
        send_pkt(5'h02, 5'h04, 5'h01, 1, 1, 0, "R1 R8 forced zero crc");
        rd_check(3'd2, 5'h02, "R8 captured while forcing");
        rd_check(3'd1, 4'b1101, "R8 status while forcing");

        // R9: CRC over windows, field start restarts
        sendw(1, 10'h2A5, 1, 1, 1, 10'h2A5, "R9 field start word");
        for (int i = 0; i < 20; i++)
            sendw(i != 7, 10'((i * 37 + 5) % 1024), 0, i >= 4 && i <= 11, i % 5 != 4,
                  10'((i * 37 + 5) % 1024), "R9 field data");
        sendw(1, 10'h040, 1, 0, 0, 10'h040, "R9 field end");
        send_pkt(5'h00, 5'h00, 5'h00, 0, 1, 0, "R9 forced crc 1");
        for (int i = 0; i < 9; i++)
            sendw(1, 10'((i * 91 + 17) % 1024), 0, i % 2 == 0, 1,
                  10'((i * 91 + 17) % 1024), "R9 field 2");
        sendw(1, 10'h155, 1, 1, 1, 10'h155, "R9 start on window word");
        sendw(1, 10'h0F0, 0, 1, 0, 10'h0F0, "R9 field 3");
        sendw(1, 10'h000, 1, 0, 0, 10'h000, "R9 field 3 end");
        send_pkt(5'h08, 5'h10, 5'h00, 1, 1, 0, "R9 forced crc 2");
        rd_check(3'd1, 4'b1000, "R7 only IDA/UES set");

        // R3: force but disabled again
        wr(3'd0, 8'h02);
        send_pkt(5'h01, 5'h01, 5'h01, 0, 0, 0, "R3 force without enable");
        rd_check(3'd2, 5'h08, "R3 flags kept");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule